// File: doc/BRIEF.md
# Intra-cluster lane duplication checker

This block adds redundant execution to one SIMT cluster of four lanes by reusing lanes that the active mask leaves idle. During register read it takes the per-lane active mask and each lane's two operands. It steers the operands of an active lane onto an inactive partner lane, so the execution units of the idle lane repeat the same computation on the same inputs.

The lane results come back in the same cycle from the execution units. In this project those units are a combinational function in the bench. The block compares each active lane's result with its duplicate's result. One cycle later it reports, with a valid strobe, a mask of the lanes that were checked and a mask of the lanes whose pair disagreed. It also passes on a writeback mask and data in which only active lanes are enabled. The duplicate results are used only for the comparison.

Pairing is deterministic. In ascending lane order, the k-th active lane pairs with the k-th inactive lane. When there are more active lanes than idle ones, the active lanes left over go unchecked. When the cluster is fully active, no lane is checked here; such instructions are left to another checking path. When no lane is active, nothing is checked.

Top module: `lane_dup_chk`

## Requirements
- R1: In the same cycle, each paired inactive lane drives, on `exe_opa_o` and `exe_opb_o`, the operands of its partner active lane. Every other lane, whether active or unpaired, drives its own operands.
- R2: Pairing runs in ascending lane index. The k-th active lane (k counted from 0 at lane 0) pairs with the k-th inactive lane. For mask 4'b1100, lane 0 duplicates lane 2 and lane 1 duplicates lane 3. For mask 4'b0111, lane 3 duplicates lane 0.
- R3: `checked_o` bit i is 1 exactly when lane i was active and received a partner. The number of set bits equals the smaller of the active count and the inactive count.
- R4: `error_o` bit i is 1 exactly when lane i is checked and its `res_i` value differs from its partner's `res_i` value. Error bits are never set outside `checked_o`.
- R5: With all four mask bits set, `checked_o` and `error_o` are zero, whatever results arrive.
- R6: With no mask bit set, `checked_o`, `error_o` and `wb_en_o` are zero.
- R7: `chk_valid_o`, `checked_o`, `error_o`, `wb_en_o` and `wb_data_o` are registered one clock after a cycle with `valid_i` high. After a cycle with `valid_i` low, `chk_valid_o`, `checked_o`, `error_o` and `wb_en_o` are zero.
- R8: `wb_en_o` equals the active mask of the accepted cycle, and `wb_data_o` holds that cycle's `res_i`. The result of an inactive lane is therefore never enabled for writeback.
- R9: While `rst_ni` is low, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is present at register read |
| active_i | input | LANES | Active mask, bit i for lane i |
| opa_i | input | LANES x WIDTH | First operand of each lane |
| opb_i | input | LANES x WIDTH | Second operand of each lane |
| exe_opa_o | output | LANES x WIDTH | First operand steered to each lane's execution unit |
| exe_opb_o | output | LANES x WIDTH | Second operand steered to each lane's execution unit |
| res_i | input | LANES x WIDTH | Result from each lane's execution unit, same cycle |
| chk_valid_o | output | 1 | Check outcome valid |
| checked_o | output | LANES | Active lanes that had a duplicate |
| error_o | output | LANES | Checked lanes whose duplicate disagreed |
| wb_en_o | output | LANES | Writeback enable per lane |
| wb_data_o | output | LANES x WIDTH | Writeback data per lane |

## Verification
The case hardest to reach is a fault on only one side of a pair. A fault on both sides with equal values must not flag. A fault on an unpaired or inactive-only lane must also stay silent. The bench models the execution units as an adder followed by a per-lane XOR fault word. Directed cases place faults on the active side, on the duplicate side, and on unchecked lanes under masks with surplus active lanes. Random masks combined with sparse random fault words then cover the other pairings.

// File: rtl/lane_dup_pkg.sv
package lane_dup_pkg;
  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lane_dup_map.sv
module lane_dup_map #(
  parameter int LANES = 4,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]         active_i,
  output logic [LANES-1:0]         dup_en_o,
  output logic [LANES-1:0][LW-1:0] dup_src_o,
  output logic [LANES-1:0]         paired_o,
  output logic [LANES-1:0][LW-1:0] partner_o
);
  logic [LANES-1:0][LW-1:0] act_list;
  int na;
  int ni;

  always_comb begin
    act_list  = '0;
    dup_en_o  = '0;
    paired_o  = '0;
    dup_src_o = '0;
    partner_o = '0;
    na = 0;
    ni = 0;
    for (int i = 0; i < LANES; i++) begin
      if (active_i[i]) begin
        act_list[na] = LW'(i);
        na++;
      end
    end
    for (int j = 0; j < LANES; j++) begin
      dup_src_o[j] = LW'(j);
      if (!active_i[j]) begin
        // k-th idle lane takes the k-th active lane
        if (ni < na) begin
          dup_en_o[j]             = 1'b1;
          dup_src_o[j]            = act_list[ni];
          paired_o[act_list[ni]]  = 1'b1;
          partner_o[act_list[ni]] = LW'(j);
        end
        ni++;
      end
    end
  end
endmodule

// File: rtl/lane_dup_fwd.sv
module lane_dup_fwd #(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]            dup_en_i,
  input  logic [LANES-1:0][LW-1:0]    dup_src_i,
  input  logic [LANES-1:0][WIDTH-1:0] opa_i,
  input  logic [LANES-1:0][WIDTH-1:0] opb_i,
  output logic [LANES-1:0][WIDTH-1:0] opa_o,
  output logic [LANES-1:0][WIDTH-1:0] opb_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign opa_o[j] = dup_en_i[j] ? opa_i[dup_src_i[j]] : opa_i[j];
    assign opb_o[j] = dup_en_i[j] ? opb_i[dup_src_i[j]] : opb_i[j];
  end
endmodule

// File: rtl/lane_dup_cmp.sv
module lane_dup_cmp #(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [LANES-1:0]            paired_i,
  input  logic [LANES-1:0][LW-1:0]    partner_i,
  input  logic [LANES-1:0][WIDTH-1:0] res_i,
  output logic                        chk_valid_o,
  output logic [LANES-1:0]            checked_o,
  output logic [LANES-1:0]            error_o
);
  logic [LANES-1:0] mism;

  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign mism[i] = paired_i[i] && (res_i[i] != res_i[partner_i[i]]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_o <= 1'b0;
      checked_o   <= '0;
      error_o     <= '0;
    end else begin
      chk_valid_o <= valid_i;
      checked_o   <= valid_i ? paired_i : '0;
      error_o     <= valid_i ? mism : '0;
    end
  end

  AST_ERR_IN_CHECKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o & ~checked_o) == '0); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chk_valid_o |-> (checked_o == '0 && error_o == '0)); // R7
endmodule

// File: rtl/lane_dup_chk.sv
module lane_dup_chk
  import lane_dup_pkg::*;
#(
  parameter int LANES = 4,
  parameter int WIDTH = 32,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [LANES-1:0]            active_i,
  input  logic [LANES-1:0][WIDTH-1:0] opa_i,
  input  logic [LANES-1:0][WIDTH-1:0] opb_i,
  output logic [LANES-1:0][WIDTH-1:0] exe_opa_o,
  output logic [LANES-1:0][WIDTH-1:0] exe_opb_o,
  input  logic [LANES-1:0][WIDTH-1:0] res_i,
  output logic                        chk_valid_o,
  output logic [LANES-1:0]            checked_o,
  output logic [LANES-1:0]            error_o,
  output logic [LANES-1:0]            wb_en_o,
  output logic [LANES-1:0][WIDTH-1:0] wb_data_o
);
  logic [LANES-1:0]         dup_en;
  logic [LANES-1:0][LW-1:0] dup_src;
  logic [LANES-1:0]         paired;
  logic [LANES-1:0][LW-1:0] partner;

  lane_dup_map #(.LANES(LANES)) map_i (
    .active_i (active_i),
    .dup_en_o (dup_en),
    .dup_src_o(dup_src),
    .paired_o (paired),
    .partner_o(partner)
  );

  lane_dup_fwd #(.LANES(LANES), .WIDTH(WIDTH)) fwd_i (
    .dup_en_i (dup_en),
    .dup_src_i(dup_src),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .opa_o    (exe_opa_o),
    .opb_o    (exe_opb_o)
  );

  lane_dup_cmp #(.LANES(LANES), .WIDTH(WIDTH)) cmp_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .paired_i   (paired),
    .partner_i  (partner),
    .res_i      (res_i),
    .chk_valid_o(chk_valid_o),
    .checked_o  (checked_o),
    .error_o    (error_o)
  );

  // duplicate results never reach writeback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= valid_i ? active_i : '0;
      if (valid_i) wb_data_o <= res_i;
    end
  end

  AST_CHECK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> $countones(checked_o) ==
      min_u($countones($past(active_i)), LANES - $countones($past(active_i)))); // R3
  AST_CHECK_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (checked_o & ~$past(active_i)) == '0); // R3
  AST_FULL_NO_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (&active_i)) |=> (checked_o == '0 && error_o == '0)); // R5
  AST_WB_ACTIVE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> wb_en_o == $past(active_i)); // R8
  AST_DUP_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (dup_en & active_i) == '0); // R1
endmodule

// File: tb/lane_dup_chk_tb_top.sv
`timescale 1ns/1ps
module lane_dup_chk_tb_top;
  localparam int LANES = 4;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid;
  logic [LANES-1:0] active;
  logic [LANES-1:0][WIDTH-1:0] opa, opb, exa, exb, res, wb_data;
  logic [LANES-1:0][WIDTH-1:0] fault;
  logic chk_valid;
  logic [LANES-1:0] checked, error, wb_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // execution units: adder, with per-lane fault injection
  always_comb
    for (int j = 0; j < LANES; j++) res[j] = (exa[j] + exb[j]) ^ fault[j];

  lane_dup_chk #(.LANES(LANES), .WIDTH(WIDTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .active_i(active),
    .opa_i(opa), .opb_i(opb), .exe_opa_o(exa), .exe_opb_o(exb), .res_i(res),
    .chk_valid_o(chk_valid), .checked_o(checked), .error_o(error),
    .wb_en_o(wb_en), .wb_data_o(wb_data)
  );

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference pairing: src[j] = lane j duplicates, -1 when none
  task automatic model(input logic [LANES-1:0] m, output int src[LANES]);
    int al[LANES];
    int na = 0;
    int ni = 0;
    for (int i = 0; i < LANES; i++) begin
      src[i] = -1;
      if (m[i]) begin al[na] = i; na++; end
    end
    for (int j = 0; j < LANES; j++)
      if (!m[j]) begin
        if (ni < na) src[j] = al[ni];
        ni++;
      end
  endtask

  task automatic run(input logic [LANES-1:0] m, input logic [LANES-1:0][WIDTH-1:0] f);
    int src[LANES];
    logic [LANES-1:0][WIDTH-1:0] ea, eb, er;
    logic [LANES-1:0] ec, ee;
    valid = 1'b1; active = m; fault = f;
    for (int j = 0; j < LANES; j++) begin opa[j] = $urandom; opb[j] = $urandom; end
    model(m, src);
    ec = '0; ee = '0;
    for (int j = 0; j < LANES; j++) begin
      ea[j] = (src[j] >= 0) ? opa[src[j]] : opa[j];
      eb[j] = (src[j] >= 0) ? opb[src[j]] : opb[j];
      er[j] = (ea[j] + eb[j]) ^ f[j];
    end
    for (int j = 0; j < LANES; j++)
      if (src[j] >= 0) begin
        ec[src[j]] = 1'b1;
        ee[src[j]] = (er[src[j]] != er[j]);
      end
    #1;
    check("R1 R2 exe_opa", 256'(exa), 256'(ea));
    check("R1 R2 exe_opb", 256'(exb), 256'(eb));
    @(negedge clk);
    check("R7 chk_valid", 256'(chk_valid), 256'(1'b1));
    check("R3 checked", 256'(checked), 256'(ec));
    check("R4 error", 256'(error), 256'(ee));
    check("R8 wb_en", 256'(wb_en), 256'(m));
    check("R8 wb_data", 256'(wb_data), 256'(er));
  endtask

  function automatic logic [LANES-1:0][WIDTH-1:0] one_fault(int lane);
    logic [LANES-1:0][WIDTH-1:0] f = '0;
    f[lane] = 32'h0000_0100;
    return f;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    valid = 0; active = '0; opa = '0; opb = '0; fault = '0;
    #35;
    check("R9 reset chk_valid", 256'(chk_valid), 0);
    check("R9 reset masks", 256'({checked, error, wb_en}), 0);
    check("R9 reset wb_data", 256'(wb_data), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    run(4'b1100, '0);                      // R2 clean pairing
    run(4'b1100, one_fault(1));            // R4 duplicate of lane 3 faulty
    run(4'b1100, one_fault(2));            // R4 active lane 2 faulty
    run(4'b0111, one_fault(3));            // R2 lane 3 duplicates lane 0
    run(4'b0111, one_fault(2));            // R3 unchecked lane fault silent
    run(4'b1111, one_fault(0));            // R5 full mask
    check("R5 full no check", 256'({checked, error}), 0);
    run(4'b0000, one_fault(1));            // R6 empty mask
    check("R6 empty quiet", 256'({checked, error, wb_en}), 0);
    run(4'b1010, '1);                      // R4 equal faults both sides: no error
    run(4'b0001, one_fault(3));            // R1 unpaired idle lane fault silent
    valid = 1'b0;
    @(negedge clk);
    check("R7 idle chk_valid", 256'(chk_valid), 0);
    check("R7 idle masks", 256'({checked, error, wb_en}), 0);
    for (int k = 0; k < 400; k++) begin
      logic [LANES-1:0][WIDTH-1:0] f = '0;
      for (int j = 0; j < LANES; j++)
        if ($urandom_range(3) == 0) f[j] = 32'($urandom_range(7) + 1);
      run(LANES'($urandom), f);
      if ($urandom_range(7) == 0) begin
        valid = 1'b0;
        @(negedge clk);
        check("R7 random idle", 256'({chk_valid, checked, error, wb_en}), 0);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule